// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Result Register Pair

This block is a sequential integer arithmetic unit. It forms signed or unsigned products and quotients of two 32-bit operands and keeps every result in a pair of dedicated 32-bit result registers, named here the upper (`hi`) and lower (`lo`) words. A multiply leaves the full 64-bit product split across the pair. A divide leaves the quotient in `lo` and the remainder in `hi`. Neither operation ever reports an error: overflow, division by zero and the one signed quotient that cannot be represented all produce defined values silently.

A client pulses `start` with an operation code and the operands. Arithmetic operations run on a shared unsigned iterative core, with one bit processed per clock. Signed operations are turned into magnitudes before the core runs and the signs are fixed when the result is written. While the core runs, `busy` is high and any new request is dropped. When the unit is idle, the two move operations load `opa` straight into one word of the pair. The current contents of both words are always visible on `hi` and `lo` for move-from reads.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, `busy` is 0 and both `hi` and `lo` read 0.
- R2: Operation code 1 (unsigned multiply) writes the 64-bit unsigned product of `opa` and `opb`, with bits 63:32 in `hi` and bits 31:0 in `lo`.
- R3: Operation code 0 (signed multiply) writes the 64-bit two's-complement product of `opa` and `opb` in the same split. There is no overflow indication.
- R4: Operation code 3 (unsigned divide) writes the unsigned quotient `opa / opb` to `lo` and the remainder to `hi`.
- R5: Operation code 2 (signed divide) writes a quotient truncated toward zero to `lo` and a remainder carrying the dividend's sign to `hi`.
- R6: With `opb` equal to 0, both divide codes write 0xFFFFFFFF to `lo` and the unchanged dividend `opa` to `hi`, with no error indication.
- R7: A signed divide of 0x80000000 by 0xFFFFFFFF writes 0x80000000 to `lo` and 0 to `hi`, with no error indication.
- R8: An arithmetic start accepted at one clock edge sets `busy` from that edge. `busy` stays high for exactly 32 cycles. `hi` and `lo` take their new values at the same edge where `busy` falls, and they do not change before that edge.
- R9: Any `start` while `busy` is high is ignored. This covers arithmetic and move codes. The running operation completes with its own result, and no second operation follows.
- R10: When the unit is idle, operation code 4 loads `opa` into `hi` and operation code 5 loads `opa` into `lo` at the next edge. The other word is left unchanged and `busy` stays low.
- R11: Operation codes 6 and 7 change neither result word and do not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request strobe, sampled on the rising edge |
| op | input | 3 | Operation code: 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div, 4 load hi, 5 load lo |
| opa | input | 32 | First operand: multiplicand, dividend, or move data |
| opb | input | 32 | Second operand: multiplier or divisor |
| busy | output | 1 | High while an arithmetic operation is in progress |
| hi | output | 32 | Upper result word: product bits 63:32, or remainder |
| lo | output | 32 | Lower result word: product bits 31:0, or quotient |

## Verification
The hardest situation to create from the ports is a request that arrives in the middle of a running operation. Such a request must leave no trace at all: it must not load a word, start a second run or stretch `busy`. The stimulus launches a multiply and waits several cycles. While `busy` is high, it pulses a divide request and then a load-hi request. It samples `hi` and `lo` during the run, checks that `busy` lasted exactly 32 cycles in total, and checks that only the multiply result lands. The sign corners are reached by picking specific operands: the most negative dividend over minus one, and negative dividends over a zero divisor.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_MUL_S  = 3'd0,
    OP_MUL_U  = 3'd1,
    OP_DIV_S  = 3'd2,
    OP_DIV_U  = 3'd3,
    OP_LOAD_H = 3'd4,
    OP_LOAD_L = 3'd5
  } md_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } md_state_e;

  // sign handling decided at request time, applied at write-back
  typedef struct packed {
    logic is_div;
    logic neg_prod;
    logic neg_quo;
    logic neg_rem;
  } md_sign_t;

endpackage

// File: rtl/muldiv_sign_prep.sv
module muldiv_sign_prep
  import muldiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  output logic [W-1:0]    a_mag,
  output logic [W-1:0]    b_mag,
  output md_sign_t        sign
);

  logic signed_op;
  logic a_neg;
  logic b_neg;
  logic b_zero;

  always_comb begin
    signed_op = (op == OP_MUL_S) || (op == OP_DIV_S);
    a_neg     = signed_op && opa[W-1];
    b_neg     = signed_op && opb[W-1];
    b_zero    = (opb == '0);
    a_mag     = a_neg ? (~opa + 1'b1) : opa;
    b_mag     = b_neg ? (~opb + 1'b1) : opb;

    sign.is_div   = (op == OP_DIV_S) || (op == OP_DIV_U);
    sign.neg_prod = a_neg ^ b_neg;
    // a zero divisor keeps the all-ones quotient regardless of signs
    sign.neg_quo  = (a_neg ^ b_neg) && !b_zero;
    sign.neg_rem  = a_neg;
  end

endmodule

// File: rtl/muldiv_iter_core.sv
module muldiv_iter_core #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         is_div,
  input  logic [W-1:0] a_mag,
  input  logic [W-1:0] b_mag,
  output logic [W-1:0] step_hi,
  output logic [W-1:0] step_lo
);

  logic [W-1:0] acc_hi_q, acc_hi_d;
  logic [W-1:0] acc_lo_q, acc_lo_d;
  logic [W-1:0] opnd_q,   opnd_d;

  logic [W:0]   mul_sum;
  logic [W:0]   trial;
  logic [W+1:0] diff;
  logic         sub_neg;

  // one shift-add or one restoring-subtract step per cycle
  always_comb begin
    mul_sum = {1'b0, acc_hi_q} + (acc_lo_q[0] ? {1'b0, opnd_q} : '0);
    trial   = {acc_hi_q, acc_lo_q[W-1]};
    diff    = {1'b0, trial} - {2'b00, opnd_q};
    sub_neg = diff[W+1];
    if (is_div) begin
      step_hi = sub_neg ? trial[W-1:0] : diff[W-1:0];
      step_lo = {acc_lo_q[W-2:0], ~sub_neg};
    end else begin
      step_hi = mul_sum[W:1];
      step_lo = {mul_sum[0], acc_lo_q[W-1:1]};
    end
  end

  always_comb begin
    acc_hi_d = acc_hi_q;
    acc_lo_d = acc_lo_q;
    opnd_d   = opnd_q;
    if (load) begin
      acc_hi_d = '0;
      acc_lo_d = a_mag;
      opnd_d   = b_mag;
    end else if (step) begin
      acc_hi_d = step_hi;
      acc_lo_d = step_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hi_q <= '0;
      acc_lo_q <= '0;
      opnd_q   <= '0;
    end else if (load || step) begin
      acc_hi_q <= acc_hi_d;
      acc_lo_q <= acc_lo_d;
      opnd_q   <= opnd_d;
    end
  end

  // restoring divider invariant: partial remainder stays below the divisor
  p_rem_below_divisor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_div && (opnd_q != '0)) |=> (acc_hi_q < opnd_q));

endmodule

// File: rtl/muldiv_sign_fix.sv
module muldiv_sign_fix
  import muldiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  md_sign_t     sign,
  input  logic [W-1:0] raw_hi,
  input  logic [W-1:0] raw_lo,
  output logic [W-1:0] fix_hi,
  output logic [W-1:0] fix_lo
);

  localparam int unsigned DW = 2 * W;

  logic [DW-1:0] prod;
  logic [DW-1:0] prod_neg;

  always_comb begin
    prod     = {raw_hi, raw_lo};
    prod_neg = ~prod + 1'b1;
    if (sign.is_div) begin
      fix_lo = sign.neg_quo ? (~raw_lo + 1'b1) : raw_lo;
      fix_hi = sign.neg_rem ? (~raw_hi + 1'b1) : raw_hi;
    end else if (sign.neg_prod) begin
      fix_hi = prod_neg[DW-1:W];
      fix_lo = prod_neg[W-1:0];
    end else begin
      fix_hi = raw_hi;
      fix_lo = raw_lo;
    end
  end

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  output logic            busy,
  output logic [W-1:0]    hi,
  output logic [W-1:0]    lo
);

  localparam int unsigned CW   = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q;
  logic rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  md_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  md_sign_t      sign_q;
  logic [W-1:0]  hi_q, hi_d;
  logic [W-1:0]  lo_q, lo_d;

  logic         idle;
  logic         arith_req;
  logic         accept;
  logic         load_h;
  logic         load_l;
  logic         last;
  logic [W-1:0] a_mag, b_mag;
  md_sign_t     sign_new;
  logic [W-1:0] step_hi, step_lo;
  logic [W-1:0] fix_hi, fix_lo;

  muldiv_sign_prep #(.W(W)) u_prep (
    .op    (op),
    .opa   (opa),
    .opb   (opb),
    .a_mag (a_mag),
    .b_mag (b_mag),
    .sign  (sign_new)
  );

  muldiv_iter_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (accept),
    .step    (state_q == ST_RUN),
    .is_div  (sign_q.is_div),
    .a_mag   (a_mag),
    .b_mag   (b_mag),
    .step_hi (step_hi),
    .step_lo (step_lo)
  );

  muldiv_sign_fix #(.W(W)) u_fix (
    .sign   (sign_q),
    .raw_hi (step_hi),
    .raw_lo (step_lo),
    .fix_hi (fix_hi),
    .fix_lo (fix_lo)
  );

  always_comb begin
    idle      = (state_q == ST_IDLE);
    arith_req = (op == OP_MUL_S) || (op == OP_MUL_U) ||
                (op == OP_DIV_S) || (op == OP_DIV_U);
    accept    = idle && start && arith_req;
    load_h    = idle && start && (op == OP_LOAD_H);
    load_l    = idle && start && (op == OP_LOAD_L);
    last      = (state_q == ST_RUN) && (cnt_q == LAST);
  end

  // sequencing
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (accept) begin
      state_d = ST_RUN;
      cnt_d   = '0;
    end else if (state_q == ST_RUN) begin
      if (last) begin
        state_d = ST_IDLE;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // result pair
  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (last) begin
      hi_d = fix_hi;
      lo_d = fix_lo;
    end else if (load_h) begin
      hi_d = opa;
    end else if (load_l) begin
      lo_d = opa;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sign_q <= '0;
    end else if (accept) begin
      sign_q <= sign_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (last || load_h || load_l) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign busy = (state_q == ST_RUN);
  assign hi   = hi_q;
  assign lo   = lo_q;

  p_busy_from_start_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(busy) |-> $past(start));

  p_busy_length_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(busy) |-> ($past(cnt_q) == LAST));

  p_hold_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && !last) |=> ($stable(hi) && $stable(lo) && busy));

  p_load_hi_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy && start && (op == OP_LOAD_H)) |=> ((hi == $past(opa)) && $stable(lo) && !busy));

  p_load_lo_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy && start && (op == OP_LOAD_L)) |=> ((lo == $past(opa)) && $stable(hi) && !busy));

  p_unused_code_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy && start && (op > 3'd5)) |=> ($stable(hi) && $stable(lo) && !busy));

endmodule

// File: tb/test_muldiv_hilo.sv
module test_muldiv_hilo;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [2:0]  op;
  logic [31:0] opa;
  logic [31:0] opb;
  logic        busy;
  logic [31:0] hi;
  logic [31:0] lo;

  int n_checks;
  int n_fails;
  bit done;

  muldiv_hilo i_muldiv_hilo (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .op    (op),
    .opa   (opa),
    .opb   (opb),
    .busy  (busy),
    .hi    (hi),
    .lo    (lo)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  // expected result words from the requirements
  task automatic expect_words(input logic [2:0] c, input logic [31:0] a,
                              input logic [31:0] b,
                              output logic [31:0] eh, output logic [31:0] el);
    longint          sa, sb, sp, sq, sr;
    longint unsigned up;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (c)
      3'd0: begin sp = sa * sb; eh = sp[63:32]; el = sp[31:0]; end
      3'd1: begin up = {32'd0, a} * {32'd0, b}; eh = up[63:32]; el = up[31:0]; end
      3'd2: begin
        if (b == 32'd0) begin eh = a; el = 32'hFFFF_FFFF; end
        else begin sq = sa / sb; sr = sa % sb; eh = sr[31:0]; el = sq[31:0]; end
      end
      default: begin
        if (b == 32'd0) begin eh = a; el = 32'hFFFF_FFFF; end
        else begin eh = a % b; el = a / b; end
      end
    endcase
  endtask

  task automatic run_arith(input string req, input logic [2:0] c,
                           input logic [31:0] a, input logic [31:0] b);
    logic [31:0] eh, el, hi0, lo0;
    int cyc;
    expect_words(c, a, b, eh, el);
    @(negedge clk);
    hi0 = hi; lo0 = lo;
    start = 1'b1; op = c; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0; opa = 32'h5A5A_5A5A; opb = 32'hA5A5_A5A5;
    cyc = 0;
    while (busy && cyc < 100) begin
      if (cyc == 31) begin
        check("R8", "hi before final edge", hi, hi0);
        check("R8", "lo before final edge", lo, lo0);
      end
      cyc++;
      @(negedge clk);
    end
    check("R8", "busy cycles", 32'(cyc), 32'd32);
    check(req, "hi", hi, eh);
    check(req, "lo", lo, el);
  endtask

  task automatic t_reset;
    check("R1", "busy after reset", {31'd0, busy}, 32'd0);
    check("R1", "hi after reset", hi, 32'd0);
    check("R1", "lo after reset", lo, 32'd0);
  endtask

  task automatic t_unsigned_mul;
    run_arith("R2", 3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_arith("R2", 3'd1, 32'h1234_5678, 32'h9ABC_DEF0);
    run_arith("R2", 3'd1, 32'h0000_0000, 32'hDEAD_BEEF);
  endtask

  task automatic t_signed_mul;
    run_arith("R3", 3'd0, 32'hFFFF_FFF9, 32'd6);
    run_arith("R3", 3'd0, 32'h8000_0000, 32'h8000_0000);
    run_arith("R3", 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_arith("R3", 3'd0, 32'h7FFF_FFFF, 32'h8000_0001);
  endtask

  task automatic t_unsigned_div;
    run_arith("R4", 3'd3, 32'd100, 32'd7);
    run_arith("R4", 3'd3, 32'hFFFF_FFFF, 32'h0001_0000);
    run_arith("R4", 3'd3, 32'd5, 32'd9);
    run_arith("R4", 3'd3, 32'h8000_0000, 32'hFFFF_FFFF);
  endtask

  task automatic t_signed_div;
    run_arith("R5", 3'd2, 32'hFFFF_FFF9, 32'd2);
    run_arith("R5", 3'd2, 32'd7, 32'hFFFF_FFFE);
    run_arith("R5", 3'd2, 32'hFFFF_FFF9, 32'hFFFF_FFFE);
    run_arith("R5", 3'd2, 32'd1000, 32'd33);
  endtask

  task automatic t_div_zero;
    run_arith("R6", 3'd3, 32'h0000_1234, 32'd0);
    run_arith("R6", 3'd2, 32'hFFFF_FFFB, 32'd0);
    run_arith("R6", 3'd2, 32'h8000_0000, 32'd0);
  endtask

  task automatic t_div_overflow;
    run_arith("R7", 3'd2, 32'h8000_0000, 32'hFFFF_FFFF);
  endtask

  task automatic t_ignore_start;
    int cyc;
    @(negedge clk);
    start = 1'b1; op = 3'd1; opa = 32'h0001_0000; opb = 32'h0003_0000;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    repeat (4) begin @(negedge clk); cyc++; end
    start = 1'b1; op = 3'd3; opa = 32'd9; opb = 32'd2;
    @(negedge clk); cyc++;
    op = 3'd4; opa = 32'hDEAD_0000;
    @(negedge clk); cyc++;
    start = 1'b0;
    check("R9", "busy mid-run", {31'd0, busy}, 32'd1);
    check("R9", "hi mid-run", hi, 32'h0000_0000);
    while (busy && cyc < 100) begin cyc++; @(negedge clk); end
    check("R9", "busy cycles with late starts", 32'(cyc - 1), 32'd32);
    check("R9", "hi keeps first result", hi, 32'h0000_0003);
    check("R9", "lo keeps first result", lo, 32'h0000_0000);
    @(negedge clk);
    check("R9", "no second run", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_moves;
    logic [31:0] keep;
    @(negedge clk);
    keep = lo;
    start = 1'b1; op = 3'd4; opa = 32'hCAFE_F00D; opb = 32'h1111_1111;
    @(negedge clk);
    start = 1'b0;
    check("R10", "hi after load", hi, 32'hCAFE_F00D);
    check("R10", "lo untouched by hi load", lo, keep);
    check("R10", "busy on load", {31'd0, busy}, 32'd0);
    keep = hi;
    start = 1'b1; op = 3'd5; opa = 32'h0BAD_1DEA;
    @(negedge clk);
    start = 1'b0;
    check("R10", "lo after load", lo, 32'h0BAD_1DEA);
    check("R10", "hi untouched by lo load", hi, keep);
  endtask

  task automatic t_unused_codes;
    logic [31:0] h0, l0;
    h0 = hi; l0 = lo;
    for (int c = 6; c < 8; c++) begin
      @(negedge clk);
      start = 1'b1; op = 3'(c); opa = 32'h7777_7777; opb = 32'd3;
      @(negedge clk);
      start = 1'b0;
      check("R11", "busy on unused code", {31'd0, busy}, 32'd0);
      @(negedge clk);
      check("R11", "hi on unused code", hi, h0);
      check("R11", "lo on unused code", lo, l0);
      check("R11", "still idle", {31'd0, busy}, 32'd0);
    end
  endtask

  initial begin
    done  = 1'b0;
    start = 1'b0;
    op    = 3'd0;
    opa   = 32'd0;
    opb   = 32'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_unsigned_mul();
    t_signed_mul();
    t_unsigned_div();
    t_signed_div();
    t_div_zero();
    t_div_overflow();
    t_ignore_start();
    t_moves();
    t_unused_codes();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule